// File: doc/BRIEF.md
# Multi-register zip/unzip interleaver

This block sequences register-to-register moves that merge up to three separate source vectors into one interleaved destination vector (zip), or split one interleaved vector back into up to three separate vectors (unzip). A start strobe latches the operation, the stream count, one base register index per separate vector, the base index of the interleaved vector, the vector length, the sub-vector length and the source and destination element widths. The block then issues one register read per clock on its read port and, one cycle later, the matching register write on its write port, with done pulsing once after the final write.

When the sub-vector length is 2, 3 or 4, every group of that many consecutive registers moves as one contiguous unit, so the interleave works on whole groups rather than on single registers. Read data is returned combinationally by the surrounding register file. Only zero-extension and truncation are applied between element widths. A base index of zero on the second or third separate vector removes that stream and everything after it.

Top module: `zu_interleave`

## Requirements
- R1: With one active stream, zip writes register vec_base+p with the value of register lane0_base+p, for p = 0 up to vl*s-1 in ascending order (s = subvl_i+1).
- R2: With two active streams and s = 1, zip writes vec_base+2i from lane0_base+i and vec_base+2i+1 from lane1_base+i.
- R3: With three active streams and s = 1, zip writes vec_base+3i, +3i+1 and +3i+2 from element i of lanes 0, 1 and 2 respectively.
- R4: Unzip (unzip_i = 1) is the inverse mapping: register vec_base+(i*n+k)*s+j is read and written to lane k base + i*s+j, for n of 2 or 3 streams.
- R5: For subvl_i = 1, 2 or 3 (group size s = 2, 3, 4), the general mapping is interleaved position (i*n+k)*s+j against lane offset i*s+j, j < s, so each group stays contiguous.
- R6: Stream count is nstreams_i (0 and 1 both mean one); stream 1 counts only if lane1_base_i is nonzero, stream 2 only if stream 1 counts and lane2_base_i is nonzero.
- R7: Width codes 0, 1, 2, 3 mean 8, 16, 32, 64 bits; the written value is the read value with all bits at or above the smaller of the two widths cleared.
- R8: Exactly one transfer per clock: the first write appears two cycles after the start edge is sampled, the rest follow on consecutive cycles in interleaved-position order.
- R9: done_o is a single-cycle pulse in the cycle after the final write.
- R10: A start strobe while busy_o is high is ignored and does not change the running transfer.
- R11: A start with vl_i = 0 makes no reads or writes and pulses done_o two cycles after the start edge.
- R12: In reset, busy_o, rd_vld_o, wr_vld_o and done_o are low.
- R13: Register indices wrap modulo the register count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken when idle |
| unzip_i | input | 1 | 0 = zip, 1 = unzip |
| nstreams_i | input | 2 | Requested stream count (0/1 = one) |
| lane0_base_i | input | REG_AW | Base register of separate vector 0 |
| lane1_base_i | input | REG_AW | Base register of separate vector 1, zero = absent |
| lane2_base_i | input | REG_AW | Base register of separate vector 2, zero = absent |
| vec_base_i | input | REG_AW | Base register of the interleaved vector |
| vl_i | input | clog2(MAX_VL+1) | Vector length in groups |
| subvl_i | input | 2 | Group size minus one |
| src_ew_i | input | 2 | Source element width code |
| dst_ew_i | input | 2 | Destination element width code |
| busy_o | output | 1 | Reads in progress |
| rd_vld_o | output | 1 | Read request valid |
| rd_idx_o | output | REG_AW | Read register index |
| rd_data_i | input | DATA_W | Read data, same cycle |
| wr_vld_o | output | 1 | Write valid |
| wr_idx_o | output | REG_AW | Write register index |
| wr_data_o | output | DATA_W | Write data |
| done_o | output | 1 | Completion pulse |

## Verification
Zip is run with one, two and three streams on distinct, non-overlapping lane bases, so a swapped lane or a wrong stride lands a recognisable value at the wrong index. Unzip with two and three streams, and group sizes of three and four in both directions, separate the per-lane offset from the interleaved position, which coincide only when s = 1. A zero third base with three requested streams tells stream dropping apart from a plain two-stream run, and widening and narrowing width pairs show which of the two widths bounds the mask. A zero-length start and a start pulse in mid-run cover the idle edge cases.

// File: rtl/zu_pkg.sv
package zu_pkg;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } ew_e;

  function automatic logic [63:0] ew_mask(ew_e ew);
    case (ew)
      EW_8:    ew_mask = 64'h0000_0000_0000_00FF;
      EW_16:   ew_mask = 64'h0000_0000_0000_FFFF;
      EW_32:   ew_mask = 64'h0000_0000_FFFF_FFFF;
      default: ew_mask = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/zu_seq.sv
module zu_seq
  import zu_pkg::*;
#(
  parameter int unsigned REG_AW = 7,
  parameter int unsigned VLW    = 7,
  parameter int unsigned OW     = 9,
  parameter int unsigned TW     = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   unzip_i,
  input  logic [1:0]             nstreams_i,
  input  logic [2:0][REG_AW-1:0] base_i,
  input  logic [REG_AW-1:0]      vbase_i,
  input  logic [VLW-1:0]         vl_i,
  input  logic [1:0]             subvl_i,
  input  ew_e                    sew_i,
  input  ew_e                    dew_i,
  output logic                   busy_o,
  output logic                   last_o,
  output logic                   zero_o,
  output logic [1:0]             lane_o,
  output logic [OW-1:0]          off_o,
  output logic [TW-1:0]          pos_o,
  output logic                   unzip_o,
  output logic [2:0][REG_AW-1:0] base_o,
  output logic [REG_AW-1:0]      vbase_o,
  output ew_e                    sew_o,
  output ew_e                    dew_o
);

  logic                   busy_q, zero_q, unzip_q;
  logic [1:0]             ncode_q, scode_q;
  logic [VLW-1:0]         vl_q;
  logic [2:0][REG_AW-1:0] base_q;
  logic [REG_AW-1:0]      vbase_q;
  ew_e                    sew_q, dew_q;
  logic [1:0]             j_q, k_q;
  logic [VLW-1:0]         i_q;
  logic [OW-1:0]          grp_q;
  logic [TW-1:0]          pos_q;

  logic [1:0] ncode_d;
  logic       j_wrap, k_wrap, last;

  // leading nonzero bases decide how many streams really take part
  always_comb begin
    ncode_d = 2'd0;
    if (nstreams_i >= 2'd2 && base_i[1] != '0) begin
      ncode_d = 2'd1;
      if (nstreams_i == 2'd3 && base_i[2] != '0) ncode_d = 2'd2;
    end
  end

  assign j_wrap = (j_q == scode_q);
  assign k_wrap = (k_q == ncode_q);
  assign last   = j_wrap && k_wrap && (i_q == vl_q - VLW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      zero_q  <= 1'b0;
      unzip_q <= 1'b0;
      ncode_q <= '0;
      scode_q <= '0;
      vl_q    <= '0;
      base_q  <= '0;
      vbase_q <= '0;
      sew_q   <= EW_8;
      dew_q   <= EW_8;
      j_q     <= '0;
      k_q     <= '0;
      i_q     <= '0;
      grp_q   <= '0;
      pos_q   <= '0;
    end else begin
      zero_q <= !busy_q && start_i && (vl_i == '0);
      if (busy_q) begin
        pos_q <= pos_q + TW'(1);
        if (!j_wrap) begin
          j_q <= j_q + 2'd1;
        end else begin
          j_q <= '0;
          if (!k_wrap) begin
            k_q <= k_q + 2'd1;
          end else begin
            k_q   <= '0;
            i_q   <= i_q + VLW'(1);
            grp_q <= grp_q + OW'(scode_q) + OW'(1);
          end
        end
        if (last) busy_q <= 1'b0;
      end else if (start_i && vl_i != '0) begin
        busy_q  <= 1'b1;
        unzip_q <= unzip_i;
        ncode_q <= ncode_d;
        scode_q <= subvl_i;
        vl_q    <= vl_i;
        base_q  <= base_i;
        vbase_q <= vbase_i;
        sew_q   <= sew_i;
        dew_q   <= dew_i;
        j_q     <= '0;
        k_q     <= '0;
        i_q     <= '0;
        grp_q   <= '0;
        pos_q   <= '0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign last_o  = busy_q && last;
  assign zero_o  = zero_q;
  assign lane_o  = k_q;
  assign off_o   = grp_q + OW'(j_q);
  assign pos_o   = pos_q;
  assign unzip_o = unzip_q;
  assign base_o  = base_q;
  assign vbase_o = vbase_q;
  assign sew_o   = sew_q;
  assign dew_o   = dew_q;

  p_busy_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |=> busy_q);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> (ncode_q == $past(ncode_q) && vbase_q == $past(vbase_q)
                             && unzip_q == $past(unzip_q) && vl_q == $past(vl_q)));

endmodule

// File: rtl/zu_addr.sv
module zu_addr #(
  parameter int unsigned REG_AW = 7,
  parameter int unsigned OW     = 9,
  parameter int unsigned TW     = 10
) (
  input  logic                   unzip_i,
  input  logic [1:0]             lane_i,
  input  logic [OW-1:0]          off_i,
  input  logic [TW-1:0]          pos_i,
  input  logic [2:0][REG_AW-1:0] base_i,
  input  logic [REG_AW-1:0]      vbase_i,
  output logic [REG_AW-1:0]      src_idx_o,
  output logic [REG_AW-1:0]      dst_idx_o
);

  logic [REG_AW-1:0] lane_idx, vec_idx, lane_base;

  always_comb begin
    case (lane_i)
      2'd1:    lane_base = base_i[1];
      2'd2:    lane_base = base_i[2];
      default: lane_base = base_i[0];
    endcase
  end

  // indices wrap modulo the register count (R13)
  assign lane_idx = lane_base + REG_AW'(off_i);
  assign vec_idx  = vbase_i + REG_AW'(pos_i);

  assign src_idx_o = unzip_i ? vec_idx  : lane_idx;
  assign dst_idx_o = unzip_i ? lane_idx : vec_idx;

endmodule

// File: rtl/zu_conv.sv
module zu_conv
  import zu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] data_i,
  input  ew_e               sew_i,
  input  ew_e               dew_i,
  output logic [DATA_W-1:0] data_o
);

  logic [63:0] smask, dmask;

  assign smask  = ew_mask(sew_i);
  assign dmask  = ew_mask(dew_i);
  assign data_o = data_i & smask[DATA_W-1:0] & dmask[DATA_W-1:0];

endmodule

// File: rtl/zu_interleave.sv
module zu_interleave
  import zu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned REG_AW = 7,
  parameter int unsigned MAX_VL = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         unzip_i,
  input  logic [1:0]                   nstreams_i,
  input  logic [REG_AW-1:0]            lane0_base_i,
  input  logic [REG_AW-1:0]            lane1_base_i,
  input  logic [REG_AW-1:0]            lane2_base_i,
  input  logic [REG_AW-1:0]            vec_base_i,
  input  logic [$clog2(MAX_VL+1)-1:0]  vl_i,
  input  logic [1:0]                   subvl_i,
  input  logic [1:0]                   src_ew_i,
  input  logic [1:0]                   dst_ew_i,
  output logic                         busy_o,
  output logic                         rd_vld_o,
  output logic [REG_AW-1:0]            rd_idx_o,
  input  logic [DATA_W-1:0]            rd_data_i,
  output logic                         wr_vld_o,
  output logic [REG_AW-1:0]            wr_idx_o,
  output logic [DATA_W-1:0]            wr_data_o,
  output logic                         done_o
);

  localparam int unsigned VLW = $clog2(MAX_VL + 1);
  localparam int unsigned OW  = $clog2(MAX_VL * 4 + 1);
  localparam int unsigned TW  = $clog2(MAX_VL * 12 + 1);

  logic                   busy, last, zero, unzip;
  logic [1:0]             lane;
  logic [OW-1:0]          off;
  logic [TW-1:0]          pos;
  logic [2:0][REG_AW-1:0] base;
  logic [REG_AW-1:0]      vbase, src_idx, dst_idx;
  ew_e                    sew, dew;
  logic [DATA_W-1:0]      conv_data;

  logic                   wr_vld_q, wr_last_q, wr_unzip_q, done_q;
  logic [REG_AW-1:0]      wr_idx_q;
  logic [DATA_W-1:0]      wr_data_q;
  ew_e                    wr_dew_q;

  zu_seq #(.REG_AW(REG_AW), .VLW(VLW), .OW(OW), .TW(TW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .unzip_i    (unzip_i),
    .nstreams_i (nstreams_i),
    .base_i     ({lane2_base_i, lane1_base_i, lane0_base_i}),
    .vbase_i    (vec_base_i),
    .vl_i       (vl_i),
    .subvl_i    (subvl_i),
    .sew_i      (ew_e'(src_ew_i)),
    .dew_i      (ew_e'(dst_ew_i)),
    .busy_o     (busy),
    .last_o     (last),
    .zero_o     (zero),
    .lane_o     (lane),
    .off_o      (off),
    .pos_o      (pos),
    .unzip_o    (unzip),
    .base_o     (base),
    .vbase_o    (vbase),
    .sew_o      (sew),
    .dew_o      (dew)
  );

  zu_addr #(.REG_AW(REG_AW), .OW(OW), .TW(TW)) u_addr (
    .unzip_i   (unzip),
    .lane_i    (lane),
    .off_i     (off),
    .pos_i     (pos),
    .base_i    (base),
    .vbase_i   (vbase),
    .src_idx_o (src_idx),
    .dst_idx_o (dst_idx)
  );

  zu_conv #(.DATA_W(DATA_W)) u_conv (
    .data_i (rd_data_i),
    .sew_i  (sew),
    .dew_i  (dew),
    .data_o (conv_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_vld_q   <= 1'b0;
      wr_last_q  <= 1'b0;
      wr_unzip_q <= 1'b0;
      wr_idx_q   <= '0;
      wr_data_q  <= '0;
      wr_dew_q   <= EW_8;
      done_q     <= 1'b0;
    end else begin
      wr_vld_q   <= busy;
      wr_last_q  <= last;
      wr_unzip_q <= unzip;
      wr_idx_q   <= dst_idx;
      wr_data_q  <= conv_data;
      wr_dew_q   <= dew;
      done_q     <= (wr_vld_q && wr_last_q) || zero;
    end
  end

  assign busy_o    = busy;
  assign rd_vld_o  = busy;
  assign rd_idx_o  = src_idx;
  assign wr_vld_o  = wr_vld_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign done_o    = done_q;

  p_wr_follows_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |=> wr_vld_o);

  p_zip_dst_seq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_q && $past(wr_vld_q) && !$past(wr_last_q) && !wr_unzip_q)
      |-> (wr_idx_q == $past(wr_idx_q) + REG_AW'(1)));

  p_dst_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_q |-> ((wr_data_q & ~DATA_W'(ew_mask(wr_dew_q))) == '0));

  p_done_after_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_q && wr_last_q) |=> done_o);

endmodule

// File: tb/sim_zu_interleave.sv
module sim_zu_interleave;

  typedef struct packed {
    logic       unzip;
    logic [1:0] nstr;
    logic [6:0] b0;
    logic [6:0] b1;
    logic [6:0] b2;
    logic [6:0] vb;
    logic [6:0] vl;
    logic [1:0] sub;
    logic [1:0] sew;
    logic [1:0] dew;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd1, 7'd2,  7'd0,  7'd0,  7'd40, 7'd5, 2'd0, 2'd3, 2'd3}, // R1
    '{1'b0, 2'd2, 7'd2,  7'd20, 7'd0,  7'd40, 7'd4, 2'd0, 2'd2, 2'd2}, // R2
    '{1'b0, 2'd3, 7'd2,  7'd12, 7'd22, 7'd40, 7'd3, 2'd0, 2'd3, 2'd3}, // R3
    '{1'b1, 2'd2, 7'd2,  7'd20, 7'd0,  7'd60, 7'd4, 2'd0, 2'd3, 2'd3}, // R4
    '{1'b1, 2'd3, 7'd2,  7'd12, 7'd22, 7'd60, 7'd3, 2'd0, 2'd3, 2'd3}, // R4
    '{1'b0, 2'd2, 7'd2,  7'd20, 7'd0,  7'd40, 7'd2, 2'd2, 2'd3, 2'd3}, // R5
    '{1'b1, 2'd3, 7'd2,  7'd12, 7'd22, 7'd60, 7'd2, 2'd3, 2'd3, 2'd3}, // R5
    '{1'b0, 2'd3, 7'd2,  7'd20, 7'd0,  7'd40, 7'd3, 2'd0, 2'd3, 2'd3}, // R6
    '{1'b0, 2'd2, 7'd2,  7'd20, 7'd0,  7'd40, 7'd4, 2'd0, 2'd0, 2'd3}, // R7
    '{1'b0, 2'd1, 7'd120,7'd0,  7'd0,  7'd125,7'd6, 2'd0, 2'd3, 2'd1}  // R7 R13
  };
  localparam string TAGS [NV] = '{"R1", "R2", "R3", "R4", "R4", "R5", "R5", "R6", "R7", "R13"};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  vec_t        cfg = '0;
  logic        busy_o, rd_vld_o, wr_vld_o, done_o;
  logic [6:0]  rd_idx_o, wr_idx_o;
  logic [63:0] rd_data_i, wr_data_o;

  logic [63:0] mem [128];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  int          log_n = 0;
  logic [6:0]  log_idx [1024];
  logic [63:0] log_dat [1024];
  int          log_cyc [1024];
  int          done_cnt = 0;
  int          done_cyc = 0;

  int          exp_n;
  logic [6:0]  exp_idx [1024];
  logic [63:0] exp_dat [1024];

  always #10ns clk = ~clk;

  assign rd_data_i = mem[rd_idx_o];

  zu_interleave u0 (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .unzip_i      (cfg.unzip),
    .nstreams_i   (cfg.nstr),
    .lane0_base_i (cfg.b0),
    .lane1_base_i (cfg.b1),
    .lane2_base_i (cfg.b2),
    .vec_base_i   (cfg.vb),
    .vl_i         (cfg.vl),
    .subvl_i      (cfg.sub),
    .src_ew_i     (cfg.sew),
    .dst_ew_i     (cfg.dew),
    .busy_o       (busy_o),
    .rd_vld_o     (rd_vld_o),
    .rd_idx_o     (rd_idx_o),
    .rd_data_i    (rd_data_i),
    .wr_vld_o     (wr_vld_o),
    .wr_idx_o     (wr_idx_o),
    .wr_data_o    (wr_data_o),
    .done_o       (done_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (wr_vld_o && log_n < 1024) begin
        log_idx[log_n] = wr_idx_o;
        log_dat[log_n] = wr_data_o;
        log_cyc[log_n] = cyc;
        log_n++;
      end
      if (done_o) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] conv(input logic [63:0] v, input logic [1:0] s, input logic [1:0] d);
    int w;
    w = 8 << ((s < d) ? s : d);
    return (w >= 64) ? v : (v & ((64'd1 << w) - 64'd1));
  endfunction

  // expected transfers straight from the R1..R6 mapping formulas
  task automatic build_exp(input vec_t v);
    int n, s;
    logic [6:0] lb, src, dst;
    n = 1;
    if (v.nstr >= 2 && v.b1 != 0) n = (v.nstr == 3 && v.b2 != 0) ? 3 : 2;
    s = int'(v.sub) + 1;
    exp_n = 0;
    for (int i = 0; i < int'(v.vl); i++)
      for (int k = 0; k < n; k++)
        for (int j = 0; j < s; j++) begin
          lb = (k == 0) ? v.b0 : (k == 1) ? v.b1 : v.b2;
          if (!v.unzip) begin
            src = 7'(lb + i * s + j);
            dst = 7'(v.vb + (i * n + k) * s + j);
          end else begin
            src = 7'(v.vb + (i * n + k) * s + j);
            dst = 7'(lb + i * s + j);
          end
          exp_idx[exp_n] = dst;
          exp_dat[exp_n] = conv(mem[src], v.sew, v.dew);
          exp_n++;
        end
  endtask

  task automatic run(input vec_t v, input string tag, input int glitch_at);
    int c0, bad, bad_e, late;
    build_exp(v);
    @(negedge clk);
    cfg = v;
    start_i = 1'b1;
    c0 = cyc;
    log_n = 0;
    done_cnt = 0;
    done_cyc = 0;
    @(negedge clk);
    start_i = 1'b0;
    if (glitch_at > 0) begin
      repeat (glitch_at) @(negedge clk);
      cfg = TBL[1];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int w = 0; w < 3000 && done_cnt == 0; w++) @(negedge clk);
    repeat (5) @(negedge clk);

    chk(done_cnt == 1, "R9", {tag, " done pulse count"}, done_cnt, 1);
    chk(done_cyc == c0 + 2 + exp_n, "R9", {tag, " done cycle"}, done_cyc - c0, 2 + exp_n);
    chk(log_n == exp_n, tag, "write count", log_n, exp_n);
    bad = 0; bad_e = 0;
    for (int e = 0; e < exp_n && e < log_n; e++)
      if (log_idx[e] !== exp_idx[e] || log_dat[e] !== exp_dat[e]) begin
        if (bad == 0) bad_e = e;
        bad++;
      end
    chk(bad == 0, tag, "write index", log_idx[bad_e], exp_idx[bad_e]);
    chk(bad == 0, tag, "write data", log_dat[bad_e], exp_dat[bad_e]);
    late = 0;
    for (int e = 0; e < log_n; e++)
      if (log_cyc[e] != c0 + 2 + e) late++;
    chk(late == 0, "R8", {tag, " write cycles"}, late, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < 128; r++)
      mem[r] = {8'hC3 ^ 8'(r), 8'(r * 7), 16'h5A00 | 16'(r), 32'h9E37_79B9 ^ (32'(r) * 32'h0101_0101)};

    start_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !rd_vld_o && !wr_vld_o && !done_o, "R12", "outputs in reset",
        {busy_o, rd_vld_o, wr_vld_o, done_o}, 0);
    start_i = 1'b0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !wr_vld_o && !done_o, "R12", "idle after reset",
        {busy_o, wr_vld_o, done_o}, 0);

    for (int t = 0; t < NV; t++) run(TBL[t], TAGS[t], 0);

    // R11: zero length
    begin
      vec_t z;
      z = TBL[2];
      z.vl = 7'd0;
      run(z, "R11", 0);
    end

    // R10: start pulse while a run is in flight
    run(TBL[2], "R10", 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule